// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between the chip's interrupt pins and a downstream priority and vector stage. It takes one non-maskable request and a set of maskable request pins, four by default. Each pin passes through a two-flop synchronizer into the core clock domain. The block then presents one pending flag per source. The non-maskable source is sensitive to rising edges and cannot be masked. Once an edge is caught it stays latched until software acknowledges it. The block also reports a fixed interrupt type number for that source. Each maskable source can be set to edge or level sensing, and each can be masked on its own.

Two of the maskable pins, indices 2 and 3 by default, can be turned into active-low acknowledge outputs. In that mode their request input is ignored. The block drives a registered one-cycle low strobe on the pin when software acknowledges the matching low-numbered source. The pad driver enable comes out as a plain output. There is no data stream at the edge of this block. Every pin is a plain level, so there is no valid/ready handshake and no back-pressure. Software talks to the block through a write-only register port: one write strobe, a two-bit select and a data word.

Top module: `irq_front_end`

## Requirements
- R1: After reset, all pending flags are 0, both acknowledge outputs are high, both pad enables are 0, every source is in edge mode and unmasked, and both pins are request inputs.
- R2: A rising edge on the non-maskable input sets its pending flag on the third clock edge after the input changes. A pulse that lasts one clock is enough. The flag stays set after the input falls and is cleared only by writing 1 to bit 4 of the acknowledge register (select 2).
- R3: The non-maskable flag ignores the mask register (select 1), and the type output always reads 2.
- R4: A maskable source in edge mode latches a rising edge. Its pending flag rises on the third clock edge after the input. The flag stays set after the input falls and is cleared only by writing 1 to that source's bit i in the acknowledge register.
- R5: When mode register (select 0) bit i is 1, source i is level sensed. Its pending flag follows the synchronized input two clock edges after the pin changes, so a request dropped before service is lost. A rising edge seen in level mode is not latched.
- R6: When mask register (select 1) bit i is 1, pending flag i is held at 0. An edge latched meanwhile is kept, and the flag shows it as soon as the mask bit is cleared.
- R7: When direction register (select 3) bit j is 1, pin 2+j is an acknowledge output: its request input is ignored and pad enable j is 1.
- R8: With direction bit j set, writing 1 to acknowledge bit j drives acknowledge output j low for exactly the one cycle after the write. With direction bit j clear, the output stays high.
- R9: An acknowledge write clears only the sources whose bits are 1. Other latched edges stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request pin, active high, asynchronous |
| irq_in | input | NUM_IRQ | Maskable request pins, active high, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 mask, 2 acknowledge, 3 direction |
| reg_wdata | input | NUM_IRQ+1 | Write data, bit i for source i, bit NUM_IRQ for the non-maskable source |
| nmi_pend | output | 1 | Non-maskable request pending |
| nmi_type | output | 8 | Interrupt type number of the non-maskable request |
| irq_pend | output | NUM_IRQ | Maskable requests pending |
| ack_n_out | output | ACK_PINS | Active-low acknowledge strobes for the shared pins |
| ack_oe | output | ACK_PINS | Pad output enables for the shared pins |

## Verification
The bench sends a non-maskable pulse that lasts only one clock, with every mask bit set. A design that sampled the pulse level instead of latching the edge, or that let the mask reach this path, would show no pending flag. It masks an edge and then unmasks it. A design that dropped the latch while masked would never raise the flag. It also drops a level-mode request before service and switches back to edge mode. This catches a design that keeps a lost level request, or that latched an edge while level sensing was selected. A pin in acknowledge mode gets a request and an acknowledge write. A design that still listened to the pin would raise a flag, and one with a wrong strobe width would fail the one-cycle check.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic lvl_i,
  input  logic level_mode_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic pend_o
);
  logic latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            latch_q <= 1'b0;
    else if (level_mode_i) latch_q <= 1'b0;
    else if (rise_i)       latch_q <= 1'b1;
    else if (clr_i)        latch_q <= 1'b0;
  end

  always_comb begin
    if (mask_i)            pend_o = 1'b0;
    else if (level_mode_i) pend_o = lvl_i;
    else                   pend_o = latch_q;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr_i && !level_mode_i) |=> latch_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_i) |=> !latch_q);
  assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && mask_i && !clr_i && !level_mode_i) |=> latch_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_fe_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int ACK_PINS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_IRQ:0]    wdata_i,
  output logic [NUM_IRQ-1:0]  mode_o,
  output logic [NUM_IRQ-1:0]  mask_o,
  output logic [ACK_PINS-1:0] dir_o,
  output logic [NUM_IRQ-1:0]  clr_o,
  output logic                nmi_clr_o,
  output logic [ACK_PINS-1:0] ack_n_o
);
  localparam int NMI_BIT = NUM_IRQ;

  reg_sel_e sel;
  logic     ack_wr;
  logic [ACK_PINS-1:0] fire;

  assign sel    = reg_sel_e'(addr_i);
  assign ack_wr = we_i && (sel == SEL_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      mask_o <= '0;
      dir_o  <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_MODE: mode_o <= wdata_i[NUM_IRQ-1:0];
        SEL_MASK: mask_o <= wdata_i[NUM_IRQ-1:0];
        SEL_DIR:  dir_o  <= wdata_i[ACK_PINS-1:0];
        default:  ;
      endcase
    end
  end

  assign clr_o     = ack_wr ? wdata_i[NUM_IRQ-1:0] : '0;
  assign nmi_clr_o = ack_wr && wdata_i[NMI_BIT];

  for (genvar j = 0; j < ACK_PINS; j++) begin : g_ack
    assign fire[j] = ack_wr && wdata_i[j] && dir_o[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_n_o[j] <= 1'b1;
      else        ack_n_o[j] <= !fire[j];
    end

    assert_strobe_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n_o[j] && !fire[j]) |=> ack_n_o[j]);
    assert_strobe_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_o[j]) |=> ack_n_o[j]);
  end
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
  parameter int NUM_IRQ     = 4,
  parameter int ACK_PINS    = 2,
  parameter int ACK_BASE    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_TYPE    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nmi_in,
  input  logic [NUM_IRQ-1:0]  irq_in,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [NUM_IRQ:0]    reg_wdata,
  output logic                nmi_pend,
  output logic [7:0]          nmi_type,
  output logic [NUM_IRQ-1:0]  irq_pend,
  output logic [ACK_PINS-1:0] ack_n_out,
  output logic [ACK_PINS-1:0] ack_oe
);
  localparam int SRC = NUM_IRQ + 1;

  logic [NUM_IRQ-1:0]  mode_q, mask_q, clr;
  logic [ACK_PINS-1:0] dir_q;
  logic                nmi_clr;
  logic [NUM_IRQ-1:0]  gated;
  logic [SRC-1:0]      s_lvl, s_rise;

  irq_regs #(.NUM_IRQ(NUM_IRQ), .ACK_PINS(ACK_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .mode_o(mode_q), .mask_o(mask_q), .dir_o(dir_q),
    .clr_o(clr), .nmi_clr_o(nmi_clr), .ack_n_o(ack_n_out)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_gate
    if (i >= ACK_BASE && i < ACK_BASE + ACK_PINS) begin : g_shared
      assign gated[i] = irq_in[i] & ~dir_q[i-ACK_BASE];
    end else begin : g_plain
      assign gated[i] = irq_in[i];
    end
  end

  irq_sync #(.W(SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({nmi_in, gated}),
    .q_o(s_lvl), .rise_o(s_rise)
  );

  irq_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .rise_i(s_rise[NUM_IRQ]), .lvl_i(s_lvl[NUM_IRQ]),
    .level_mode_i(1'b0), .mask_i(1'b0), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    irq_latch u_lat (
      .clk(clk), .rst_n(rst_n), .rise_i(s_rise[i]), .lvl_i(s_lvl[i]),
      .level_mode_i(mode_q[i]), .mask_i(mask_q[i]), .clr_i(clr[i]),
      .pend_o(irq_pend[i])
    );
    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[i] |-> !irq_pend[i]);
  end

  assign ack_oe   = dir_q;
  assign nmi_type = 8'(NMI_TYPE);

  assert_nmi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_clr) |=> nmi_pend);
  assert_nmi_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(nmi_type));
endmodule

// File: tb/sim_irq_front_end.sv
module sim_irq_front_end;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         nmi_in = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [N:0]   reg_wdata = '0;
  logic         nmi_pend;
  logic [7:0]   nmi_type;
  logic [N-1:0] irq_pend;
  logic [1:0]   ack_n_out, ack_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_front_end u0 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .nmi_pend(nmi_pend), .nmi_type(nmi_type), .irq_pend(irq_pend),
    .ack_n_out(ack_n_out), .ack_oe(ack_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    check(irq_pend == 0, "R1 irq_pend", irq_pend, 0);
    check(nmi_pend == 0, "R1 nmi_pend", nmi_pend, 0);
    check(ack_n_out == 2'b11, "R1 ack_n_out", ack_n_out, 3);
    check(ack_oe == 2'b00, "R1 ack_oe", ack_oe, 0);
  endtask

  task automatic t_nmi;
    wr(2'd1, 5'h0F);
    nmi_in = 1'b1; cyc(1); nmi_in = 1'b0;
    cyc(1);
    check(nmi_pend == 0, "R2 early", nmi_pend, 0);
    cyc(1);
    check(nmi_pend == 1, "R2 one-clock pulse caught", nmi_pend, 1);
    check(nmi_type == 8'd2, "R3 type", nmi_type, 2);
    cyc(5);
    check(nmi_pend == 1, "R3 held while masked", nmi_pend, 1);
    wr(2'd2, 5'h0F);
    check(nmi_pend == 1, "R2 only bit4 clears", nmi_pend, 1);
    wr(2'd2, 5'h10);
    check(nmi_pend == 0, "R2 cleared", nmi_pend, 0);
    wr(2'd1, 5'h00);
  endtask

  task automatic t_edge;
    irq_in[0] = 1'b1;
    cyc(2);
    check(irq_pend[0] == 0, "R4 latency", irq_pend[0], 0);
    cyc(1);
    check(irq_pend[0] == 1, "R4 set", irq_pend[0], 1);
    irq_in[0] = 1'b0;
    cyc(4);
    check(irq_pend[0] == 1, "R4 held after fall", irq_pend[0], 1);
    wr(2'd2, 5'h01);
    check(irq_pend[0] == 0, "R4 cleared", irq_pend[0], 0);
  endtask

  task automatic t_level;
    wr(2'd0, 5'h04);
    irq_in[2] = 1'b1;
    cyc(2);
    check(irq_pend[2] == 1, "R5 level follows", irq_pend[2], 1);
    wr(2'd2, 5'h04);
    check(irq_pend[2] == 1, "R5 ack no effect", irq_pend[2], 1);
    irq_in[2] = 1'b0;
    cyc(2);
    check(irq_pend[2] == 0, "R5 dropped request lost", irq_pend[2], 0);
    wr(2'd0, 5'h00);
    cyc(3);
    check(irq_pend[2] == 0, "R5 no latch in level mode", irq_pend[2], 0);
  endtask

  task automatic t_mask;
    wr(2'd1, 5'h02);
    irq_in[1] = 1'b1; cyc(1); irq_in[1] = 1'b0;
    cyc(4);
    check(irq_pend[1] == 0, "R6 masked", irq_pend[1], 0);
    wr(2'd1, 5'h00);
    check(irq_pend[1] == 1, "R6 kept edge shows", irq_pend[1], 1);
    wr(2'd2, 5'h02);
    check(irq_pend[1] == 0, "R6 cleared", irq_pend[1], 0);
  endtask

  task automatic t_dir;
    wr(2'd3, 5'h01);
    check(ack_oe == 2'b01, "R7 pad enable", ack_oe, 1);
    irq_in[2] = 1'b1;
    cyc(4);
    check(irq_pend[2] == 0, "R7 input ignored", irq_pend[2], 0);
    irq_in[2] = 1'b0;
    wr(2'd2, 5'h03);
    check(ack_n_out == 2'b10, "R8 strobe low", ack_n_out, 2);
    cyc(1);
    check(ack_n_out == 2'b11, "R8 strobe one cycle", ack_n_out, 3);
    wr(2'd3, 5'h00);
    cyc(3);
    check(irq_pend[2] == 0, "R7 no stray edge", irq_pend[2], 0);
    wr(2'd2, 5'h01);
    check(ack_n_out == 2'b11, "R8 no strobe without dir", ack_n_out, 3);
  endtask

  task automatic t_select;
    irq_in[0] = 1'b1; irq_in[3] = 1'b1;
    cyc(3);
    irq_in = '0;
    check(irq_pend == 4'b1001, "R9 both set", irq_pend, 9);
    wr(2'd2, 5'h01);
    check(irq_pend == 4'b1000, "R9 selective clear", irq_pend, 8);
    wr(2'd2, 5'h08);
    check(irq_pend == 4'b0000, "R9 all clear", irq_pend, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_nmi();
    t_edge();
    t_level();
    t_mask();
    t_dir();
    t_select();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule